// File: doc/BRIEF.md
# SerDes Operating Mode and Direction Controller

This block turns two static mode pins and a direction pin into the operating state of a bidirectional serializer/deserializer. A zero code on both mode pins powers the link down and holds the rest of the device in reset. Any other code powers the link up and names the reference frequency band. The direction pin then chooses between the transmit role and the receive role. The block produces the enables that the serializer, the deserializer and the parallel pin drivers use. It also produces the inverted direction, which a partner device uses as its own direction input.

The block also decides which clock the transmitter runs from. After power-up the transmitter uses an externally supplied bit clock. A small detector watches a reference-clock level in the system clock domain. Once it has counted enough rising edges, the block switches to reference-clock operation. That choice is kept until the next power-down, even if the reference stops. Every output is registered, so each one follows its inputs by exactly one system clock.

Top module: `serdes_mode_ctl`

## Requirements
- R1: With mode code 00 on `mode_i`, on the next clock `core_rst_o` is 1 and `tx_en_o`, `rx_en_o`, `par_oe_o`, `wclk_hold_o`, `half_rate_o` are 0, and `range_o` is 00.
- R2: With a nonzero mode code, on the next clock `range_o` equals the code (01 = lowest band, 10 = middle band, 11 = highest band). `half_rate_o` is 1 only for code 11.
- R3: `dir_n_o` equals the inverse of `dir_i` one clock later, in every mode including power-down.
- R4: `par_oe_o` and `rx_en_o` are 1 exactly when, at the previous clock, `dir_i` was 0 and the mode code was nonzero.
- R5: With `dir_i` = 1 and a nonzero mode code, on the next clock `tx_en_o` = 1 and `wclk_hold_o` = 1 (word clock held high), while `rx_en_o` and `par_oe_o` are 0.
- R6: `core_rst_o` goes to 0 exactly one clock after the mode code leaves 00. It goes to 1 one clock after the code returns to 00.
- R7: `ref_clk_sel_o` is 0 on leaving power-down. It becomes 1 only after `MIN_EDGES` (default 4) rising edges of `ref_lvl_i` have been seen while the mode code is nonzero. Fewer edges leave it at 0.
- R8: Once set, `ref_clk_sel_o` stays at 1 when `ref_lvl_i` stops and while direction or band changes. Power-down clears it, together with any partial edge count.
- R9: Synchronous reset `rst` puts the outputs in the power-down state with `dir_n_o` = 1 and `ref_clk_sel_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Mode pins: 00 power-down, otherwise band code |
| dir_i | input | 1 | Direction: 1 transmit, 0 receive |
| ref_lvl_i | input | 1 | Raw reference-clock level (asynchronous) |
| dir_n_o | output | 1 | Inverted direction for the partner device |
| tx_en_o | output | 1 | Serializer enable |
| rx_en_o | output | 1 | Deserializer enable, also loads the dedicated outputs |
| par_oe_o | output | 1 | Parallel bidirectional pin drive enable |
| wclk_hold_o | output | 1 | Hold the word-clock output high |
| core_rst_o | output | 1 | Global reset for the device core |
| range_o | output | 2 | Reference band select |
| half_rate_o | output | 1 | Divide-by-two serial rate |
| ref_clk_sel_o | output | 1 | 1: reference clock, 0: external bit clock |

## Verification
A wrong decode shows on the next clock as a mismatched enable, band or reset bit. For example, a receive-mode drive enable that is left on during transmit would cause bus contention on the parallel pins. A fault in the edge counter or the sticky clock-source flag shows as `ref_clk_sel_o` changing a few clocks too early or too late relative to the edge count. It can also show as the flag being lost when the reference stops or surviving a power-down. The bench therefore counts edges exactly at the threshold, one short of it, and across a power-down that interrupts a partial count.

// File: rtl/serdes_mode_ctl_pkg.sv
package serdes_mode_ctl_pkg;

    localparam int MODE_W  = 2;
    localparam int RANGE_W = 2;

    localparam logic [MODE_W-1:0] MODE_OFF  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_FAST = 2'b11;

    typedef enum logic [1:0] {
        OP_OFF = 2'd0,
        OP_TX  = 2'd1,
        OP_RX  = 2'd2
    } op_e;

    typedef struct packed {
        logic               dir_n;
        logic               tx_en;
        logic               rx_en;
        logic               par_oe;
        logic               wclk_hold;
        logic               core_rst;
        logic [RANGE_W-1:0] range;
        logic               half_rate;
    } ctl_word_t;

    function automatic op_e classify(input logic [MODE_W-1:0] mode, input logic dir);
        if (mode == MODE_OFF) return OP_OFF;
        return dir ? OP_TX : OP_RX;
    endfunction

    function automatic ctl_word_t idle_word();
        ctl_word_t w;
        w           = '0;
        w.dir_n     = 1'b1;
        w.core_rst  = 1'b1;
        return w;
    endfunction

    function automatic ctl_word_t decode_ctl(input logic [MODE_W-1:0] mode, input logic dir);
        ctl_word_t w;
        op_e       op;
        op    = classify(mode, dir);
        w     = '0;
        w.dir_n = ~dir;
        case (op)
            OP_OFF: begin
                w.core_rst = 1'b1;
            end
            OP_TX: begin
                w.tx_en     = 1'b1;
                w.wclk_hold = 1'b1;
            end
            default: begin
                w.rx_en  = 1'b1;
                w.par_oe = 1'b1;
            end
        endcase
        if (op != OP_OFF) begin
            w.range     = RANGE_W'(mode);
            w.half_rate = (mode == MODE_FAST);
        end
        return w;
    endfunction

endpackage

// File: rtl/scx_mode_decode.sv
module scx_mode_decode
    import serdes_mode_ctl_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              dir_i,
    output ctl_word_t         word_o,
    output logic              pd_o
);

    always_comb begin
        word_o = decode_ctl(mode_i, dir_i);
        pd_o   = (classify(mode_i, dir_i) == OP_OFF);
    end

endmodule

// File: rtl/scx_ref_detect.sv
module scx_ref_detect #(
    parameter int MIN_EDGES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic ref_lvl_i,
    output logic active_o
);

    localparam int CNT_W = $clog2(MIN_EDGES) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_EDGES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   active_q;
    logic                   rise;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else if (i == 0) sync_q[i] <= ref_lvl_i;
                else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (rise && !active_q) begin
            if (cnt_q == LAST) active_q <= 1'b1;
            else               cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign active_o = active_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);  // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        $past(clear_i) |-> !active_q && cnt_q == '0);  // R8

endmodule

// File: rtl/scx_clksrc_latch.sv
module scx_clksrc_latch (
    input  logic clk,
    input  logic rst,
    input  logic pd_i,
    input  logic ref_active_i,
    output logic ref_sel_o
);

    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst || pd_i) sel_q <= 1'b0;
        else if (ref_active_i) sel_q <= 1'b1;
    end

    assign ref_sel_o = sel_q;

    AST_SEL_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(sel_q) && !$past(pd_i) |-> sel_q);  // R8

    AST_SEL_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_q) |-> $past(ref_active_i));  // R7

endmodule

// File: rtl/serdes_mode_ctl.sv
module serdes_mode_ctl
    import serdes_mode_ctl_pkg::*;
#(
    parameter int MIN_EDGES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_i,
    input  logic         dir_i,
    input  logic         ref_lvl_i,
    output logic         dir_n_o,
    output logic         tx_en_o,
    output logic         rx_en_o,
    output logic         par_oe_o,
    output logic         wclk_hold_o,
    output logic         core_rst_o,
    output logic [1:0]   range_o,
    output logic         half_rate_o,
    output logic         ref_clk_sel_o
);

    ctl_word_t next_word;
    ctl_word_t word_q;
    logic      pd;
    logic      ref_active;

    scx_mode_decode u_decode (
        .mode_i (mode_i),
        .dir_i  (dir_i),
        .word_o (next_word),
        .pd_o   (pd)
    );

    scx_ref_detect #(
        .MIN_EDGES   (MIN_EDGES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_detect (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (pd),
        .ref_lvl_i (ref_lvl_i),
        .active_o  (ref_active)
    );

    scx_clksrc_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .pd_i         (pd),
        .ref_active_i (ref_active),
        .ref_sel_o    (ref_clk_sel_o)
    );

    always_ff @(posedge clk) begin
        if (rst) word_q <= idle_word();
        else     word_q <= next_word;
    end

    assign dir_n_o     = word_q.dir_n;
    assign tx_en_o     = word_q.tx_en;
    assign rx_en_o     = word_q.rx_en;
    assign par_oe_o    = word_q.par_oe;
    assign wclk_hold_o = word_q.wclk_hold;
    assign core_rst_o  = word_q.core_rst;
    assign range_o     = word_q.range;
    assign half_rate_o = word_q.half_rate;

    AST_PD_RESET: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(mode_i) == 2'b00 |-> core_rst_o && !tx_en_o && !rx_en_o && !par_oe_o);  // R1

    AST_HALF_FAST: assert property (@(posedge clk) disable iff (rst)
        half_rate_o |-> range_o == 2'b11);  // R2

    AST_DIR_INV: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dir_n_o == !$past(dir_i));  // R3

    AST_OE_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> rx_en_o && !core_rst_o && !tx_en_o);  // R4

    AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_en_o, rx_en_o, core_rst_o}));  // R5

    AST_EXIT_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(mode_i) != 2'b00 |-> !core_rst_o);  // R6

endmodule

// File: tb/serdes_mode_ctl_test.sv
module serdes_mode_ctl_test;

    localparam int MIN_EDGES = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic       dir_i = 1'b0;
    logic       ref_lvl_i = 1'b0;
    logic       dir_n_o, tx_en_o, rx_en_o, par_oe_o, wclk_hold_o, core_rst_o;
    logic [1:0] range_o;
    logic       half_rate_o, ref_clk_sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serdes_mode_ctl #(.MIN_EDGES(MIN_EDGES)) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .dir_i(dir_i), .ref_lvl_i(ref_lvl_i),
        .dir_n_o(dir_n_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .par_oe_o(par_oe_o),
        .wclk_hold_o(wclk_hold_o), .core_rst_o(core_rst_o), .range_o(range_o),
        .half_rate_o(half_rate_o), .ref_clk_sel_o(ref_clk_sel_o)
    );

    // {dir_n, tx, rx, oe, hold, rst, range[1:0], half}
    function automatic logic [8:0] model(input logic [1:0] m, input logic d);
        logic pd;
        pd = (m == 2'b00);
        return {~d, !pd && d, !pd && !d, !pd && !d, !pd && d, pd,
                pd ? 2'b00 : m, m == 2'b11};
    endfunction

    function automatic logic [8:0] observed();
        return {dir_n_o, tx_en_o, rx_en_o, par_oe_o, wclk_hold_o, core_rst_o, range_o, half_rate_o};
    endfunction

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apply(input logic [1:0] m, input logic d);
        mode_i = m;
        dir_i  = d;
        tick(1);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ref_lvl_i = 1'b1; tick(3);
            ref_lvl_i = 1'b0; tick(3);
        end
        tick(6);
    endtask

    initial begin
        logic [8:0] e;
        void'($urandom(32'd1234));
        tick(2);
        check("R9 reset word", observed(), 9'b1_0000_1_00_0);
        check("R9 reset clksel", {8'd0, ref_clk_sel_o}, 9'd0);
        rst = 1'b0;

        apply(2'b00, 1'b1);
        check("R1 pd with dir high", observed(), model(2'b00, 1'b1));
        check("R3 dir_n in pd", {8'd0, dir_n_o}, 9'd0);
        apply(2'b01, 1'b1);
        check("R6 exit after one clk", {8'd0, core_rst_o}, 9'd0);
        check("R5 tx lowest band", observed(), model(2'b01, 1'b1));
        apply(2'b11, 1'b0);
        check("R4 rx highest band", observed(), model(2'b11, 1'b0));
        check("R2 half rate on 11", {8'd0, half_rate_o}, 9'd1);
        apply(2'b10, 1'b0);
        check("R2 middle band", {7'd0, range_o}, 9'd2);
        apply(2'b00, 1'b0);
        check("R6 entry after one clk", {8'd0, core_rst_o}, 9'd1);
        check("R1 pd from rx", observed(), model(2'b00, 1'b0));

        for (int i = 0; i < 300; i++) begin
            logic [1:0] m;
            logic d;
            m = 2'($urandom_range(0, 3));
            d = 1'($urandom_range(0, 1));
            apply(m, d);
            e = model(m, d);
            if (m == 2'b00)  check("R1 random pd", observed(), e);
            else if (d)      check("R5 random tx", observed(), e);
            else             check("R4 random rx", observed(), e);
            check("R3 random dir", {8'd0, dir_n_o}, {8'd0, ~d});
            check("R2 random band", {6'd0, range_o, half_rate_o}, {6'd0, e[2:0]});
            check("R7 no ref no switch", {8'd0, ref_clk_sel_o}, 9'd0);
        end

        apply(2'b00, 1'b1);
        apply(2'b01, 1'b1);
        check("R7 leave pd on external clock", {8'd0, ref_clk_sel_o}, 9'd0);
        pulses(MIN_EDGES - 1);
        check("R7 one edge short", {8'd0, ref_clk_sel_o}, 9'd0);
        pulses(1);
        check("R7 threshold reached", {8'd0, ref_clk_sel_o}, 9'd1);
        tick(20);
        check("R8 ref stopped kept", {8'd0, ref_clk_sel_o}, 9'd1);
        apply(2'b11, 1'b0);
        apply(2'b10, 1'b1);
        check("R8 kept across dir/band", {8'd0, ref_clk_sel_o}, 9'd1);
        apply(2'b00, 1'b1);
        check("R8 cleared by pd", {8'd0, ref_clk_sel_o}, 9'd0);

        apply(2'b10, 1'b1);
        pulses(MIN_EDGES - 1);
        apply(2'b00, 1'b1);
        tick(2);
        apply(2'b10, 1'b1);
        pulses(1);
        check("R8 partial count cleared by pd", {8'd0, ref_clk_sel_o}, 9'd0);
        pulses(MIN_EDGES - 1);
        check("R7 full count after pd", {8'd0, ref_clk_sel_o}, 9'd1);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule